// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block produces the four gate commands of a full bridge as two complementary legs. Both legs run at a fixed half-period high time; delivered power is set by how far the second leg lags the first. The leading leg (gates A and B) is aligned to the block's own period counter. The lagging leg (gates C and D) follows the same waveform, shifted later by a digitised phase command.

Each leg inserts a turn-on dead time before every rising edge. The two legs have separately programmed dead times. A dead time can never be zero, and it is limited so that every gate keeps at least one high cycle per half period.

A period-start strobe starts or restarts the period counter. The period then repeats on its own after the programmed number of clock cycles. The period length, phase command and both dead times are taken only at period boundaries. A force-off input pulls all four gates low in the same cycle, with no sequencing.

Top module: `pshift_bridge`

## Requirements
- R1: After reset, and until the first `periodStart` pulse, all four gates are low.
- R2: A boundary is a clock edge where `periodStart` is high, or the last position of a running period. At a boundary the length L is taken from `periodLen` (see R12), and the half length is H = floor(L/2). In the cycle after a boundary the position p is 0, and it then counts up by one per cycle through L-1. `gateA` is high for p in [dAB, H) and `gateB` is high for p in [H+dAB, L).
- R3: `gateA` and `gateB` are never high together, and neither are `gateC` and `gateD`.
- R4: The lagging leg uses the position q = (p - S) mod L, where S is the shift in cycles. `gateC` is high for q in [dCD, H) and `gateD` is high for q in [H+dCD, L). Outside R5 and R6, S equals `phaseCmd`.
- R5: A `phaseCmd` above H saturates, so S = H, a shift of half a period.
- R6: A `phaseCmd` below ZERO_TH (default 2) gives exactly S = 0.
- R7: dAB is derived only from `deadAb`, and dCD only from `deadCd`.
- R8: The effective dead time is the programmed value clamped to the range [DT_MIN, H-1], with DT_MIN = 1 by default. A gate never rises in the cycle in which its partner falls, except on the lagging leg in the first cycle after a boundary that changes S or L.
- R9: While `forceOff` is high, all four gates are low in that same cycle. When it is released, switching resumes on the unchanged period timeline.
- R10: `periodLen`, `phaseCmd`, `deadAb` and `deadCd` affect the outputs only through the values sampled at a boundary.
- R11: A `periodStart` pulse restarts the period from any position, so the next cycle has p = 0.
- R12: A `periodLen` below 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodStart | input | 1 | Starts or restarts the period |
| periodLen | input | CNT_W (8) | Period length in clock cycles |
| phaseCmd | input | CNT_W (8) | Lag of the C-D leg in cycles, full scale is half a period |
| deadAb | input | DT_W (4) | Dead time of the A-B leg in cycles |
| deadCd | input | DT_W (4) | Dead time of the C-D leg in cycles |
| forceOff | input | 1 | Drives all gates low at once |
| gateA | output | 1 | Leading leg, first half |
| gateB | output | 1 | Leading leg, second half |
| gateC | output | 1 | Lagging leg, first half |
| gateD | output | 1 | Lagging leg, second half |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a `periodStart` restart and the automatic wrap, or a mid-period change of the sampled inputs. The bench pulses `periodStart` at several positions, including one cycle before the natural wrap. It also changes every configuration input in the middle of a period, and it judges each cycle against a position model that only re-samples at boundaries. The second pair is `forceOff` and a gate edge. Force-off is raised right at a dead-time boundary, and the gates are read in that same cycle before the next edge.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  // strobes passed from the period control to the gate datapath
  typedef struct packed {
    logic load;  // boundary: take new configuration, restart position
    logic run;   // a period has been started since reset
  } ctlStrobe_t;
endpackage

// File: rtl/pshift_ctrl.sv
module pshift_ctrl
  import pshift_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic [CNT_W-1:0] periodLen,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] lenNext,
  output logic [CNT_W-1:0] lenCur
);
  localparam logic [CNT_W-1:0] MinLen = CNT_W'(MIN_LEN);

  logic running;
  logic wrap;

  assign lenNext  = (periodLen < MinLen) ? MinLen : periodLen;
  assign wrap     = running && (pos == lenCur - 1'b1);
  assign ctl.load = periodStart || wrap;
  assign ctl.run  = running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      lenCur  <= MinLen;
      running <= 1'b0;
    end else if (ctl.load) begin
      pos     <= '0;
      lenCur  <= lenNext;
      running <= 1'b1;
    end else if (running) begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/pshift_path.sv
module pshift_path
  import pshift_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DT_W    = 4,
  parameter int DT_MIN  = 1,
  parameter int ZERO_TH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             forceOff,
  input  ctlStrobe_t       ctl,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] lenNext,
  input  logic [CNT_W-1:0] lenCur,
  input  logic [CNT_W-1:0] phaseCmd,
  input  logic [DT_W-1:0]  deadAb,
  input  logic [DT_W-1:0]  deadCd,
  output logic [3:0]       gates    // {A, B, C, D}
);
  localparam logic [CNT_W-1:0] ZeroTh  = CNT_W'(ZERO_TH);
  localparam logic [CNT_W-1:0] DeadMin = CNT_W'(DT_MIN);
  localparam int               NLEG    = 2;

  logic [CNT_W-1:0] halfNext;
  logic [CNT_W-1:0] shiftNext;
  logic [CNT_W-1:0] halfR;
  logic [CNT_W-1:0] shiftR;

  function automatic logic [CNT_W-1:0] clampDead(input logic [DT_W-1:0] d,
                                                 input logic [CNT_W-1:0] h);
    logic [CNT_W-1:0] v;
    v = CNT_W'(d);
    if (v < DeadMin) v = DeadMin;
    if (v > h - 1'b1) v = h - 1'b1;
    return v;
  endfunction

  always_comb begin
    halfNext = lenNext >> 1;
    if (phaseCmd < ZeroTh)        shiftNext = '0;
    else if (phaseCmd > halfNext) shiftNext = halfNext;
    else                          shiftNext = phaseCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfR  <= '0;
      shiftR <= '0;
    end else if (ctl.load) begin
      halfR  <= halfNext;
      shiftR <= shiftNext;
    end
  end

  for (genvar g = 0; g < NLEG; g++) begin : gLeg
    logic [DT_W-1:0]  deadIn;
    logic [CNT_W-1:0] deadR;
    logic [CNT_W-1:0] legPos;
    logic             firstOn;
    logic             secondOn;

    assign deadIn = (g == 0) ? deadAb : deadCd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         deadR <= DeadMin;
      else if (ctl.load) deadR <= clampDead(deadIn, halfNext);
    end

    if (g == 0) begin : gLead
      assign legPos = pos;
    end else begin : gLag
      // shiftR never exceeds half the period, so the sum stays below lenCur
      assign legPos = (pos >= shiftR) ? (pos - shiftR) : (pos + (lenCur - shiftR));
    end

    assign firstOn  = (legPos >= deadR) && (legPos < halfR);
    assign secondOn = legPos >= (halfR + deadR);

    assign gates[3-2*g] = ctl.run && !forceOff && firstOn;
    assign gates[2-2*g] = ctl.run && !forceOff && secondOn;
  end
endmodule

// File: rtl/pshift_bridge.sv
module pshift_bridge
  import pshift_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DT_W    = 4,
  parameter int DT_MIN  = 1,
  parameter int ZERO_TH = 2,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic [CNT_W-1:0] periodLen,
  input  logic [CNT_W-1:0] phaseCmd,
  input  logic [DT_W-1:0]  deadAb,
  input  logic [DT_W-1:0]  deadCd,
  input  logic             forceOff,
  output logic             gateA,
  output logic             gateB,
  output logic             gateC,
  output logic             gateD
);
  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] lenNext;
  logic [CNT_W-1:0] lenCur;
  logic [3:0]       gates;

  pshift_ctrl #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .periodLen(periodLen),
    .ctl(ctl), .pos(pos), .lenNext(lenNext), .lenCur(lenCur)
  );

  pshift_path #(.CNT_W(CNT_W), .DT_W(DT_W), .DT_MIN(DT_MIN), .ZERO_TH(ZERO_TH)) path_i (
    .clk(clk), .rstN(rstN), .forceOff(forceOff), .ctl(ctl), .pos(pos),
    .lenNext(lenNext), .lenCur(lenCur), .phaseCmd(phaseCmd),
    .deadAb(deadAb), .deadCd(deadCd), .gates(gates)
  );

  assign gateA = gates[3];
  assign gateB = gates[2];
  assign gateC = gates[1];
  assign gateD = gates[0];
endmodule

// File: rtl/pshift_bridge_chk.sv
module pshift_bridge_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             periodStart,
  input logic             forceOff,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] pos,
  input logic             gateA,
  input logic             gateB,
  input logic             gateC,
  input logic             gateD
);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !(gateA || gateB || gateC || gateD));

  a_r3_lead_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA && gateB));

  a_r3_lag_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(gateC && gateD));

  a_r8_lead_gap_a: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateA) |-> !gateB);

  a_r8_lead_gap_b: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateB) |-> !gateA);

  a_r8_lag_gap_c: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateC) && !$past(load)) |-> !gateD);

  a_r8_lag_gap_d: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateD) && !$past(load)) |-> !gateC);

  a_r9_force_low: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |-> !(gateA || gateB || gateC || gateD));

  a_r11_restart: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> (run && (pos == '0)));
endmodule

bind pshift_bridge pshift_bridge_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .periodStart(periodStart), .forceOff(forceOff),
  .run(ctl.run), .load(ctl.load), .pos(pos),
  .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD)
);

// File: tb/pshift_bridge_tb_top.sv
module pshift_bridge_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       periodStart;
  logic [7:0] periodLen;
  logic [7:0] phaseCmd;
  logic [3:0] deadAb;
  logic [3:0] deadCd;
  logic       forceOff;
  logic       gateA, gateB, gateC, gateD;

  always #5 clk = ~clk;

  pshift_bridge dut_i (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .periodLen(periodLen),
    .phaseCmd(phaseCmd), .deadAb(deadAb), .deadCd(deadCd), .forceOff(forceOff),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  int mCnt, mLen, mHalf, mShift;
  int mDead[2];
  bit mRun;

  function automatic int clampDead(int v, int h);
    if (v < 1) v = 1;
    if (v > h - 1) v = h - 1;
    return v;
  endfunction

  function automatic logic [3:0] expGates();
    logic [3:0] e;
    int q;
    e = 4'b0000;
    if (mRun && !forceOff) begin
      for (int g = 0; g < 2; g++) begin
        q = (g == 0) ? mCnt : (mCnt - mShift + mLen) % mLen;
        e[3-2*g] = (q >= mDead[g]) && (q < mHalf);
        e[2-2*g] = (q >= mHalf + mDead[g]);
      end
    end
    return e;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: gates ABCD got %b expected %b (model pos %0d len %0d)",
               tag, got, exp, mCnt, mLen);
    end
  endtask

  task automatic tick(string tag);
    int nl, h;
    bit bnd;
    @(posedge clk);
    bnd = periodStart || (mRun && (mCnt == mLen - 1));
    if (bnd) begin
      nl      = (periodLen < 4) ? 4 : int'(periodLen);
      h       = nl / 2;
      mLen    = nl;
      mHalf   = h;
      mShift  = (phaseCmd < 2) ? 0 : ((int'(phaseCmd) > h) ? h : int'(phaseCmd));
      mDead[0] = clampDead(int'(deadAb), h);
      mDead[1] = clampDead(int'(deadCd), h);
      mCnt    = 0;
      mRun    = 1'b1;
    end else if (mRun) begin
      mCnt++;
    end
    @(negedge clk);
    check(tag, {gateA, gateB, gateC, gateD}, expGates());
    nChk++;
    if ((gateA && gateB) || (gateC && gateD)) begin
      nFail++;
      $display("FAIL R3: gates ABCD got %b expected no pair both high",
               {gateA, gateB, gateC, gateD});
    end
  endtask

  initial begin
    int lens[5];
    lens = '{2, 5, 8, 9, 13};
    rstN = 1'b0; periodStart = 1'b0; periodLen = 8'd8; phaseCmd = 8'd0;
    deadAb = 4'd1; deadCd = 4'd1; forceOff = 1'b0;
    mCnt = 0; mLen = 4; mHalf = 2; mShift = 0; mDead[0] = 1; mDead[1] = 1; mRun = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {gateA, gateB, gateC, gateD}, 4'b0000);
    rstN = 1'b1;
    repeat (5) tick("R1");

    // first start: L=8, H=4, shift 0, dead 1/1
    periodStart = 1'b1; tick("R2"); periodStart = 1'b0;
    repeat (16) tick("R2");

    // sweep of length, shift and dead-time pairs
    for (int li = 0; li < 5; li++) begin
      for (int di = 0; di < 4; di++) begin
        int effL, h;
        effL = (lens[li] < 4) ? 4 : lens[li];
        h = effL / 2;
        for (int ph = 0; ph <= h + 2; ph++) begin
          string tag;
          periodLen = 8'(lens[li]);
          phaseCmd  = 8'(ph);
          deadAb = (di == 0) ? 4'd0 : (di == 1) ? 4'd1 : (di == 2) ? 4'd3 : 4'd15;
          deadCd = (di == 0) ? 4'd0 : (di == 1) ? 4'd3 : (di == 2) ? 4'd1 : 4'd2;
          if (lens[li] < 4)       tag = "R12";
          else if (ph > h)        tag = "R5";
          else if (ph < 2)        tag = "R6";
          else if (di == 0 || di == 3) tag = "R8";
          else if (di == 2)       tag = "R7";
          else                    tag = "R4";
          repeat (2 * effL) tick(tag);
        end
      end
    end

    // mid-period input changes take effect only at the next boundary
    periodLen = 8'd10; phaseCmd = 8'd3; deadAb = 4'd2; deadCd = 4'd2;
    periodStart = 1'b1; tick("R10"); periodStart = 1'b0;
    repeat (4) tick("R10");
    periodLen = 8'd14; phaseCmd = 8'd6; deadAb = 4'd1; deadCd = 4'd4;
    repeat (30) tick("R10");

    // restart from assorted positions, including just before the wrap
    for (int k = 0; k < 4; k++) begin
      repeat (3 + 4 * k) tick("R11");
      periodStart = 1'b1; tick("R11"); periodStart = 1'b0;
    end
    repeat (12) tick("R11");
    periodStart = 1'b1; tick("R11"); periodStart = 1'b0;
    repeat (12) tick("R11");
    periodStart = 1'b1; tick("R11"); periodStart = 1'b0;
    repeat (20) tick("R11");

    // force-off: immediate low, then resume on the same timeline
    repeat (1) tick("R9");
    forceOff = 1'b1;
    #1;
    check("R9", {gateA, gateB, gateC, gateD}, 4'b0000);
    repeat (9) tick("R9");
    forceOff = 1'b0;
    #1;
    check("R9", {gateA, gateB, gateC, gateD}, expGates());
    repeat (20) tick("R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule